// File: doc/BRIEF.md
# Quad-Lane Page-Program Receiver

This block is the device side of a serial-flash page-program transfer carried on four data lanes. While the chip select is low, it takes an 8-bit command code one bit per serial-clock rise on lane 0. It then takes a 24-bit address and the data bytes one nibble per serial-clock rise on all four lanes. The command is accepted only if the code matches, the write-enable latch is set, the quad-enable input is high and no program cycle is in progress. Each completed data byte clears bits in a small on-chip byte array. The new cell value is the old value ANDed with the byte received.

The serial clock, chip select and lanes are sampled by the system clock `clk`. An edge on the serial clock is recognised by comparing its present value with its registered value. When the chip select rises after an accepted transfer that carried at least one whole byte, a busy flag stays high for a fixed number of system clocks. When the flag drops, the write-enable latch is cleared. A combinational read port exposes the array contents, so the effect of each transfer can be observed.

Top module: `quad_prog_rx`

## Requirements
- R1: A programmed cell takes the value (old value AND received byte), so a bit can only go from 1 to 0.
- R2: If the write-enable latch is 0 when the eighth code bit is sampled, the transfer is ignored: the array and the busy flag do not change.
- R3: If `qe` is 0 when the eighth code bit is sampled, the transfer is ignored and the write-enable latch keeps its value.
- R4: The code is taken MSB first from `dq_in[0]` only, one bit per serial-clock rise, and lanes 3..1 are ignored during that phase. A code other than `OPCODE` makes the transfer ignored, and the latch keeps its value.
- R5: The address is taken as 6 nibbles, most significant nibble first. Each data byte is taken as 2 nibbles, high nibble first. `dq_in[3]` is the MSB of every nibble.
- R6: Only whole data bytes are programmed. A trailing half byte is discarded. A transfer with no whole byte does not start a program cycle and leaves the latch set.
- R7: The array index is the low log2(`MEM_BYTES`) address bits. After each byte the low 8 address bits increment and wrap within the 256-byte page, while the higher bits stay fixed.
- R8: `wip` goes high on the first `clk` edge that samples `cs_n` high after a qualifying transfer. It stays high for exactly `PROG_CYCLES` cycles.
- R9: A one-cycle `wren` pulse while `wip` is 0 sets `wel`. `wel` returns to 0 on the same edge at which `wip` falls.
- R10: While `wip` is 1, `wren` is ignored and a new page-program transfer is rejected.
- R11: After reset, `wip` and `wel` are 0 and every array byte reads 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, sampled by clk |
| dq_in | input | 4 | Data lanes; lane 3 is the nibble MSB |
| wren | input | 1 | One-cycle write-enable command pulse |
| qe | input | 1 | Quad-enable bit level |
| rd_addr | input | log2(MEM_BYTES) | Array read address |
| rd_data | output | 8 | Array byte at rd_addr |
| wel | output | 1 | Write-enable latch |
| wip | output | 1 | Program cycle in progress |

## Verification
An array byte changes at the `clk` edge that samples the serial-clock rise carrying its low nibble, and `rd_data` shows it from that cycle on. `wip` rises at the edge that first samples `cs_n` high and falls `PROG_CYCLES` edges later, together with `wel`. The bench model applies these rules edge by edge to the same sampled inputs. All outputs are compared half a period after each edge, after the read address has settled. Directed checks then count the cycles for which `wip` is high and read back the expected bytes once each transfer is over.

// File: rtl/quad_prog_rx.sv
module quad_prog_rx #(
  parameter int MEM_BYTES   = 512,
  parameter int PROG_CYCLES = 40,
  parameter logic [7:0] OPCODE = 8'h38,
  localparam int AW = $clog2(MEM_BYTES),
  localparam int CW = $clog2(PROG_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sck,
  input  logic [3:0]    dq_in,
  input  logic          wren,
  input  logic          qe,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          wel,
  output logic          wip
);

  typedef enum logic [1:0] {S_CODE, S_ADDR, S_DATA, S_SKIP} st_t;

  st_t           st;
  logic          sck_q, cs_q;
  logic [3:0]    cnt;
  logic [6:0]    code_sr;
  logic [AW-1:0] addr;
  logic [3:0]    hi_nib;
  logic          hi_valid, got_byte;
  logic [CW-1:0] wcnt;
  logic [7:0]    mem [MEM_BYTES];

  wire       shift    = sck & ~sck_q & ~cs_n;
  wire       cs_rise  = cs_n & ~cs_q;
  wire [7:0] code_now = {code_sr, dq_in[0]};
  wire       accept   = (code_now == OPCODE) & wel & qe & ~wip;
  wire       wr_byte  = shift & (st == S_DATA) & hi_valid;
  wire       done     = wip & (wcnt == CW'(1));

  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_CODE;
      cnt      <= '0;
      code_sr  <= '0;
      addr     <= '0;
      hi_nib   <= '0;
      hi_valid <= 1'b0;
      got_byte <= 1'b0;
    end else if (cs_n) begin
      st       <= S_CODE;
      cnt      <= '0;
      hi_valid <= 1'b0;
      got_byte <= 1'b0;
    end else if (shift) begin
      case (st)
        S_CODE: begin
          code_sr <= code_now[6:0];
          cnt     <= cnt + 4'd1;
          if (cnt == 4'd7) begin
            st  <= accept ? S_ADDR : S_SKIP;
            cnt <= '0;
          end
        end
        S_ADDR: begin
          addr <= {addr[AW-5:0], dq_in};
          cnt  <= cnt + 4'd1;
          if (cnt == 4'd5) begin
            st  <= S_DATA;
            cnt <= '0;
          end
        end
        S_DATA: begin
          if (hi_valid) begin
            addr[7:0] <= addr[7:0] + 8'd1;
            hi_valid  <= 1'b0;
            got_byte  <= 1'b1;
          end else begin
            hi_nib   <= dq_in;
            hi_valid <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
    end else if (wr_byte) begin
      mem[addr] <= mem[addr] & {hi_nib, dq_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wip  <= 1'b0;
      wcnt <= '0;
    end else if (cs_rise && st == S_DATA && got_byte) begin
      wip  <= 1'b1;
      wcnt <= CW'(PROG_CYCLES);
    end else if (done) begin
      wip  <= 1'b0;
    end else if (wip) begin
      wcnt <= wcnt - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            wel <= 1'b0;
    else if (done)         wel <= 1'b0;
    else if (wren && !wip) wel <= 1'b1;
  end

endmodule

// File: rtl/quad_prog_rx_chk.sv
module quad_prog_rx_chk #(
  parameter int PROG_CYCLES = 40,
  parameter int AW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          wip,
  input logic          wel,
  input logic [AW-1:0] rd_addr,
  input logic [7:0]    rd_data
);

  int run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   run <= 0;
    else if (wip) run <= run + 1;
    else          run <= 0;
  end

  p_wip_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wip |-> run < PROG_CYCLES);

  p_wip_exact_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> run == PROG_CYCLES);

  p_wip_after_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(cs_n));

  p_wip_needs_wel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(wel));

  p_wel_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wip |-> wel);

  p_wel_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> !wel);

  p_bits_fall_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(rd_addr) |-> ((rd_data & ~$past(rd_data)) == 8'h00));

endmodule

bind quad_prog_rx quad_prog_rx_chk #(.PROG_CYCLES(PROG_CYCLES), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wip(wip), .wel(wel),
  .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/test_quad_prog_rx.sv
module test_quad_prog_rx;
  localparam int P  = 40;
  localparam int MB = 512;
  localparam logic [7:0] OP = 8'h38;

  logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, wren = 0, qe = 0;
  logic [3:0] dq_in = 0;
  logic [8:0] rd_addr = 0, hold_addr = 0;
  logic hold = 0;
  logic [7:0] rd_data;
  logic wel, wip;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  quad_prog_rx #(.MEM_BYTES(MB), .PROG_CYCLES(P), .OPCODE(OP)) i_quad_prog_rx (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .dq_in(dq_in),
    .wren(wren), .qe(qe), .rd_addr(rd_addr), .rd_data(rd_data),
    .wel(wel), .wip(wip));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model, advanced on every edge from the sampled inputs
  bit m_wip, m_wel, m_acc, m_got, p_sck, p_cs;
  bit [7:0] m_op, exp_mem [MB];
  bit [3:0] m_hi;
  int m_ph, m_nib, m_wc, m_addr;

  always @(posedge clk) begin
    bit nw, nl;
    if (!rst_n) begin
      m_wip = 0; m_wel = 0; m_acc = 0; m_got = 0; p_sck = 0; p_cs = 1;
      m_ph = 0; m_nib = 0; m_wc = 0; m_addr = 0; m_op = 0;
      foreach (exp_mem[i]) exp_mem[i] = 8'hFF;
    end else begin
      nw = m_wip; nl = m_wel;
      if (cs_n) begin
        if (!p_cs == 1 && m_acc && m_got) begin nw = 1; m_wc = P; end
        m_ph = 0; m_acc = 0; m_got = 0; m_nib = 0;
      end else if (sck && !p_sck) begin
        if (m_ph < 8) begin
          m_op = {m_op[6:0], dq_in[0]};
          if (m_ph == 7) m_acc = (m_op == OP) && m_wel && qe && !m_wip;
        end else if (m_acc) begin
          if (m_ph < 14) m_addr = ((m_addr << 4) | int'(dq_in)) & 32'hFFFFFF;
          else begin
            if (m_nib % 2 == 0) m_hi = dq_in;
            else begin
              exp_mem[m_addr % MB] &= {m_hi, dq_in};
              m_addr = (m_addr & ~32'hFF) | ((m_addr + 1) & 32'hFF);
              m_got = 1;
            end
            m_nib++;
          end
        end
        m_ph++;
      end
      if (m_wip) begin
        if (m_wc == 1) begin nw = 0; nl = 0; end
        else m_wc--;
      end
      if (wren && !m_wip) nl = 1;
      m_wip = nw; m_wel = nl;
      p_sck = sck; p_cs = cs_n;
    end
  end

  always @(negedge clk) rd_addr <= hold ? hold_addr : rd_addr + 9'd1;

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      chk("R8 wip vs model", wip, m_wip);
      chk("R9 wel vs model", wel, m_wel);
      chk("R1 rd_data vs model", rd_data, exp_mem[rd_addr]);
    end
  end

  task automatic mem_is(input string req, input logic [8:0] a, input logic [7:0] v);
    hold_addr = a; hold = 1;
    @(negedge clk); #1;
    chk(req, rd_data, v);
    hold = 0;
  endtask

  task automatic pulse(input logic [3:0] d);
    dq_in = d; sck = 1;
    @(negedge clk);
    sck = 0;
    @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] op, input logic [23:0] a,
                      input logic [7:0] bytes[$], input bit half);
    cs_n = 0;
    @(negedge clk);
    for (int i = 7; i >= 0; i--) pulse({3'(i * 3 + 1), op[i]});
    for (int k = 5; k >= 0; k--) pulse(a[k*4 +: 4]);
    foreach (bytes[j]) begin
      pulse(bytes[j][7:4]);
      pulse(bytes[j][3:0]);
    end
    if (half) pulse(4'h0);
    cs_n = 1;
    @(negedge clk);
  endtask

  task automatic wren_pulse();
    wren = 1;
    @(negedge clk);
    wren = 0;
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (P + 4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 wip reset", wip, 0);
    chk("R11 wel reset", wel, 0);
    mem_is("R11 mem[0] erased", 9'h000, 8'hFF);
    mem_is("R11 mem[1FF] erased", 9'h1FF, 8'hFF);

    qe = 1;
    xfer(OP, 24'h000010, '{8'h00}, 0);
    chk("R2 no wip without wel", wip, 0);
    settle();
    mem_is("R2 mem unchanged", 9'h010, 8'hFF);

    wren_pulse();
    chk("R9 wel set by wren", wel, 1);
    qe = 0;
    xfer(OP, 24'h000010, '{8'h00}, 0);
    chk("R3 no wip with qe=0", wip, 0);
    settle();
    chk("R3 wel kept", wel, 1);
    mem_is("R3 mem unchanged", 9'h010, 8'hFF);

    qe = 1;
    xfer(8'h02, 24'h000010, '{8'h00}, 0);
    settle();
    chk("R4 wrong code ignored wel", wel, 1);
    mem_is("R4 wrong code mem", 9'h010, 8'hFF);

    xfer(OP, 24'h000010, '{8'hA5, 8'h3C}, 0);
    n = 0;
    while (wip && n < 1000) begin n++; @(negedge clk); end
    chk("R8 wip length", n, P);
    chk("R9 wel cleared at end", wel, 0);
    mem_is("R5 high nibble first", 9'h010, 8'hA5);
    mem_is("R5 second byte", 9'h011, 8'h3C);

    wren_pulse();
    xfer(OP, 24'h000010, '{8'h0F}, 0);
    settle();
    mem_is("R1 AND program", 9'h010, 8'h05);

    wren_pulse();
    xfer(OP, 24'hFF01FE, '{8'h11, 8'h22, 8'h33}, 0);
    settle();
    mem_is("R7 index low bits", 9'h1FE, 8'h11);
    mem_is("R7 last in page", 9'h1FF, 8'h22);
    mem_is("R7 wrap to page start", 9'h100, 8'h33);
    mem_is("R7 no spill", 9'h000, 8'hFF);

    wren_pulse();
    xfer(OP, 24'h000020, '{}, 1);
    chk("R6 no byte no wip", wip, 0);
    chk("R6 wel kept", wel, 1);
    mem_is("R6 no byte mem", 9'h020, 8'hFF);
    xfer(OP, 24'h000020, '{8'h00}, 1);
    settle();
    mem_is("R6 whole byte kept", 9'h020, 8'h00);
    mem_is("R6 half byte dropped", 9'h021, 8'hFF);

    wren_pulse();
    xfer(OP, 24'h000040, '{8'h7E}, 0);
    chk("R10 busy started", wip, 1);
    wren_pulse();
    xfer(OP, 24'h000030, '{8'h00}, 0);
    settle();
    chk("R10 wren during busy ignored", wel, 0);
    mem_is("R10 busy transfer rejected", 9'h030, 8'hFF);
    mem_is("R10 first transfer done", 9'h040, 8'h7E);

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule